// File: doc/BRIEF.md
# Palette-Indexed Pixel Decoder

This block turns raw video memory bytes into a stream of 5-bit colour codes at the pixel rate. Once per character period the fetch logic presents a 16-bit word: the upper byte is shown first, then the lower byte. Each byte lasts eight clock cycles. In each cycle the block picks the pen number that belongs to the current pixel under the active screen mode, looks it up in a sixteen-entry pen palette, and registers the result onto the output. When display enable was low at the moment a word was loaded, the whole word period shows the border colour.

The CPU programs the block through an 8-bit command port, and bits 7:6 of a command give its class. One class selects either a pen or the border. Another writes a colour number into whatever was selected. A third holds a new screen mode, and that mode is applied at the next rising edge of horizontal sync. The three pixel formats pack 2, 4 or 8 pixels into a byte. In the two wider formats, the bits of one pen number are spread across the byte rather than kept side by side.

Top module: `pixel_pen_decoder`

## Requirements
- R1: While reset is high and in the cycle after it falls, `colour` is 0.
- R2: Bits 7:6 of an accepted command select its class: 00 is a pen select, 01 is an ink write, 10 is a mode write. Bit 5 of a pen select and bits 5:2 of a mode write have no effect.
- R3: In a pen select, bit 4 set selects the border and bits 3:0 are then ignored. Otherwise bits 3:0 select a pen. An ink write stores bits 4:0 into the entry that is selected.
- R4: In mode 2 (mode write bits 1:0 = 10) each bit is one pixel held for 1 cycle, bit 7 first. The pen number is 0 or 1.
- R5: In mode 1 (bits 1:0 = 01) a byte carries four 2-bit pixels, each held for 2 cycles. Pixel k (k=0..3, first shown is 0) has pen bit 0 at byte bit 7-k and pen bit 1 at byte bit 3-k.
- R6: In mode 0 (bits 1:0 = 00) a byte carries two 4-bit pixels, each held for 4 cycles. Pixel k (k=0,1) takes pen bits 0,1,2,3 from byte bits 7-k, 3-k, 5-k, 1-k. Mode value 11 decodes like mode 0.
- R7: If `de` is low in the cycle `load` is sampled, all 16 cycles of that word show the border colour.
- R8: A mode write takes effect only at the next rising edge of `hsync`. Words loaded before that edge keep the previous mode.
- R9: An ink write changes only the colours output on clock edges after the edge that accepts it.
- R10: When `load` is sampled at clock edge n, pixel cycle i (i=0..15) of that word appears on `colour` after edge n+1+i.
- R11: A command with bits 7:6 = 11 changes no pen selection, palette entry or mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte is valid this cycle |
| cmd_data | input | 8 | Command byte |
| hsync | input | 1 | Horizontal sync; a rising edge commits the held mode |
| load | input | 1 | Capture a new video word |
| de | input | 1 | Display enable, sampled together with `load` |
| vid_word | input | 16 | Two video bytes, upper byte shown first |
| colour | output | 5 | Registered colour code |

## Verification
Every result has a fixed due cycle. Pixel i of a word loaded at edge n is due after edge n+1+i. A command accepted at edge m can first change the colour registered at edge m+1. A mode write waits for the next hsync rise. When the driver starts a word, it pushes sixteen expected colours into the scoreboard, each tagged with its absolute due cycle. The monitor compares each one only in the matching cycle, at the falling clock edge. For the mid-word ink write, the expected colours switch at exactly the pixel that follows the accepting edge.

// File: rtl/pixel_pen_pkg.sv
package pixel_pen_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    CMD_PEN_SEL = 2'b00,
    CMD_INK     = 2'b01,
    CMD_CTRL    = 2'b10,
    CMD_OTHER   = 2'b11
  } cmd_kind_e;

  localparam logic [1:0] MODE_WIDE4 = 2'd0;
  localparam logic [1:0] MODE_MID2  = 2'd1;
  localparam logic [1:0] MODE_THIN1 = 2'd2;
endpackage

// File: rtl/pen_cmd_decode.sv
module pen_cmd_decode
  import pixel_pen_pkg::*;
#(
  parameter int PEN_W   = 4,
  parameter int COLOR_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_data,
  input  logic               hsync,
  output logic [PEN_W-1:0]   pen_sel,
  output logic               sel_border,
  output logic               ink_we,
  output logic [COLOR_W-1:0] ink_val,
  output logic [1:0]         mode_act
);
  cmd_kind_e  kind;
  logic [1:0] mode_pend;
  logic       hsync_q;
  logic       unused_bit5;

  assign kind        = cmd_kind_e'(cmd_data[7:6]);
  assign ink_we      = cmd_valid && (kind == CMD_INK);
  assign ink_val     = cmd_data[COLOR_W-1:0];
  assign unused_bit5 = cmd_data[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      pen_sel    <= '0;
      sel_border <= 1'b0;
      mode_pend  <= MODE_WIDE4;
      mode_act   <= MODE_WIDE4;
      hsync_q    <= 1'b0;
    end else begin
      hsync_q <= hsync;
      if (cmd_valid && kind == CMD_PEN_SEL) begin
        sel_border <= cmd_data[4];
        pen_sel    <= cmd_data[PEN_W-1:0];
      end
      if (cmd_valid && kind == CMD_CTRL)
        mode_pend <= cmd_data[1:0];
      if (hsync && !hsync_q)
        mode_act <= mode_pend;
    end
  end
endmodule

// File: rtl/pen_shifter.sv
module pen_shifter
  import pixel_pen_pkg::*;
#(
  parameter int PEN_W = 4,
  parameter int PH_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              de,
  input  logic [WORD_W-1:0] vid_word,
  input  logic [1:0]        mode,
  output logic [PH_W-1:0]   phase,
  output logic              de_q,
  output logic [PEN_W-1:0]  pen_idx
);
  logic [WORD_W-1:0] shreg;
  logic [BYTE_W-1:0] cur;
  logic [2:0]        j;
  logic [2:0]        k1;
  logic [2:0]        k0;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      phase <= '0;
      de_q  <= 1'b0;
    end else if (load) begin
      shreg <= vid_word;
      phase <= '0;
      de_q  <= de;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // upper byte during the first half of the word period
  assign cur = phase[PH_W-1] ? shreg[BYTE_W-1:0] : shreg[WORD_W-1:BYTE_W];
  assign j   = phase[2:0];
  assign k1  = {1'b0, phase[2:1]};
  assign k0  = {2'b00, phase[2]};

  always_comb begin
    pen_idx = '0;
    unique case (mode)
      MODE_THIN1: pen_idx[0] = cur[3'd7 - j];
      MODE_MID2: begin
        pen_idx[0] = cur[3'd7 - k1];
        pen_idx[1] = cur[3'd3 - k1];
      end
      default: begin
        pen_idx[0] = cur[3'd7 - k0];
        pen_idx[1] = cur[3'd3 - k0];
        pen_idx[2] = cur[3'd5 - k0];
        pen_idx[3] = cur[3'd1 - k0];
      end
    endcase
  end
endmodule

// File: rtl/pen_palette.sv
module pen_palette #(
  parameter int PEN_W   = 4,
  parameter int COLOR_W = 5,
  parameter int PENS    = 2 ** PEN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ink_we,
  input  logic [COLOR_W-1:0] ink_val,
  input  logic               sel_border,
  input  logic [PEN_W-1:0]   pen_sel,
  input  logic [PEN_W-1:0]   pen_idx,
  input  logic               de_q,
  output logic [COLOR_W-1:0] colour
);
  logic [COLOR_W-1:0] mem [PENS];
  logic [COLOR_W-1:0] border_q;

  always_ff @(posedge clk) begin
    if (ink_we && !sel_border)
      mem[pen_sel] <= ink_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      border_q <= '0;
      colour   <= '0;
    end else begin
      if (ink_we && sel_border)
        border_q <= ink_val;
      colour <= de_q ? mem[pen_idx] : border_q;
    end
  end
endmodule

// File: rtl/pixel_pen_decoder.sv
module pixel_pen_decoder
  import pixel_pen_pkg::*;
#(
  parameter int PEN_W   = 4,
  parameter int COLOR_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_data,
  input  logic               hsync,
  input  logic               load,
  input  logic               de,
  input  logic [WORD_W-1:0]  vid_word,
  output logic [COLOR_W-1:0] colour
);
  localparam int PH_W = $clog2(WORD_W);

  logic [PEN_W-1:0]   pen_sel;
  logic               sel_border;
  logic               ink_we;
  logic [COLOR_W-1:0] ink_val;
  logic [1:0]         mode_act;
  logic [PH_W-1:0]    phase;
  logic               de_q;
  logic [PEN_W-1:0]   pen_idx;

  pen_cmd_decode #(.PEN_W(PEN_W), .COLOR_W(COLOR_W)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .hsync(hsync), .pen_sel(pen_sel), .sel_border(sel_border),
    .ink_we(ink_we), .ink_val(ink_val), .mode_act(mode_act)
  );

  pen_shifter #(.PEN_W(PEN_W), .PH_W(PH_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .de(de), .vid_word(vid_word),
    .mode(mode_act), .phase(phase), .de_q(de_q), .pen_idx(pen_idx)
  );

  pen_palette #(.PEN_W(PEN_W), .COLOR_W(COLOR_W)) u_pal (
    .clk(clk), .rst(rst), .ink_we(ink_we), .ink_val(ink_val),
    .sel_border(sel_border), .pen_sel(pen_sel), .pen_idx(pen_idx),
    .de_q(de_q), .colour(colour)
  );
endmodule

// File: rtl/pixel_pen_decoder_chk.sv
module pixel_pen_decoder_chk #(
  parameter int PEN_W   = 4,
  parameter int COLOR_W = 5,
  parameter int PH_W    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [7:0]         cmd_data,
  input logic               hsync,
  input logic [PEN_W-1:0]   pen_sel,
  input logic               sel_border,
  input logic [1:0]         mode_act,
  input logic [PH_W-1:0]    phase,
  input logic               de_q,
  input logic               ink_we,
  input logic [COLOR_W-1:0] colour
);
  // R3
  border_select_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_data[7:6] == 2'b00) |=>
      (sel_border == $past(cmd_data[4])) &&
      (sel_border || pen_sel == $past(cmd_data[PEN_W-1:0])));

  // R8
  mode_on_hsync_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_act) |-> $past(hsync));

  // R11
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_data[7:6] == 2'b11) |=> $stable(pen_sel) && $stable(sel_border));

  // R6
  pixel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (de_q && mode_act == 2'd0 && phase[1:0] != 2'b00 && $stable(mode_act) &&
     $stable(de_q) && !$past(ink_we)) |=> $stable(colour));
endmodule

bind pixel_pen_decoder pixel_pen_decoder_chk #(.PEN_W(PEN_W), .COLOR_W(COLOR_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .hsync(hsync),
  .pen_sel(pen_sel), .sel_border(sel_border), .mode_act(mode_act), .phase(phase),
  .de_q(de_q), .ink_we(ink_we), .colour(colour)
);

// File: tb/pixel_pen_decoder_tb.sv
`timescale 1ns/1ps
module pixel_pen_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_data = 8'h00;
  logic        hsync = 1'b0;
  logic        load = 1'b0;
  logic        de = 1'b0;
  logic [15:0] vid_word = 16'h0000;
  logic [4:0]  colour;

  pixel_pen_decoder u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .hsync(hsync), .load(load), .de(de), .vid_word(vid_word), .colour(colour)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [4:0] m_pal [16];
  logic [4:0] m_border = 5'd0;
  logic [1:0] m_pend = 2'd0;
  logic [1:0] m_act = 2'd0;

  int         q_due [$];
  logic [4:0] q_exp [$];
  string      q_tag [$];

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: colour=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      if (q_due[0] == cyc) check(q_tag[0], colour, q_exp[0]);
      else check({q_tag[0], " missed"}, 5'h1f, 5'h00);
      void'(q_due.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end
  end

  function automatic logic [3:0] model_pen(logic [15:0] w, logic [1:0] m, int i);
    logic [7:0] b;
    int jj;
    int kk;
    b  = (i < 8) ? w[15:8] : w[7:0];
    jj = i % 8;
    if (m == 2'd2) return {3'b000, b[7-jj]};
    if (m == 2'd1) begin
      kk = jj / 2;
      return {2'b00, b[3-kk], b[7-kk]};
    end
    kk = jj / 4;
    return {b[1-kk], b[5-kk], b[3-kk], b[7-kk]};
  endfunction

  task automatic send_cmd(logic [7:0] v);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = v;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_ink(bit to_border, int pen, logic [4:0] col);
    send_cmd(to_border ? 8'h10 : {4'h0, pen[3:0]});
    send_cmd({3'b010, col});
    if (to_border) m_border = col;
    else m_pal[pen] = col;
  endtask

  task automatic set_mode(logic [7:0] v);
    send_cmd(v);
    m_pend = v[1:0];
  endtask

  task automatic pulse_hsync();
    @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    m_act = m_pend;
  endtask

  // driver: load a word and push its sixteen expected colours
  task automatic show(logic [15:0] w, bit d, string tag);
    int k;
    @(negedge clk);
    load = 1'b1;
    vid_word = w;
    de = d;
    k = cyc;
    for (int i = 0; i < 16; i++) begin
      q_due.push_back(k + 2 + i);
      q_exp.push_back(d ? m_pal[model_pen(w, m_act, i)] : m_border);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    load = 1'b0;
    de = 1'b0;
    repeat (17) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", colour, 5'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", colour, 5'd0);

    for (int p = 0; p < 16; p++) set_ink(1'b0, p, 5'((p * 3 + 1) % 32));
    set_ink(1'b1, 0, 5'h1a);

    show(16'hA53C, 1'b1, "R6");
    show(16'h5AC3, 1'b1, "R6");

    set_mode(8'h81);
    show(16'h9E61, 1'b1, "R8");
    pulse_hsync();
    show(16'h9E61, 1'b1, "R5");
    show(16'h3C77, 1'b1, "R5");

    set_mode(8'hBE);
    pulse_hsync();
    show(16'hB40F, 1'b1, "R2");
    show(16'h6D92, 1'b1, "R4");

    set_mode(8'h83);
    pulse_hsync();
    show(16'hC3A5, 1'b1, "R6");

    show(16'hFFFF, 1'b0, "R7");

    set_mode(8'h81);
    pulse_hsync();
    send_cmd(8'h13);
    send_cmd(8'h47);
    m_border = 5'h07;
    show(16'h0000, 1'b0, "R3");
    show(16'h8888, 1'b1, "R3");

    send_cmd(8'h22);
    send_cmd(8'h4e);
    m_pal[2] = 5'h0e;
    show(16'h0808, 1'b1, "R2");

    send_cmd(8'hC5);
    send_cmd(8'hDF);
    pulse_hsync();
    show(16'h8888, 1'b1, "R11");
    show(16'h0808, 1'b1, "R11");
    show(16'h1234, 1'b0, "R11");

    set_mode(8'h82);
    pulse_hsync();
    show(16'h0F0F, 1'b1, "R10");

    begin
      int k;
      logic [4:0] old_c;
      logic [4:0] new_c;
      send_cmd(8'h01);
      old_c = m_pal[1];
      new_c = 5'h15;
      @(negedge clk);
      load = 1'b1;
      vid_word = 16'hFFFF;
      de = 1'b1;
      k = cyc;
      for (int i = 0; i < 16; i++) begin
        q_due.push_back(k + 2 + i);
        q_exp.push_back(i <= 4 ? old_c : new_c);
        q_tag.push_back("R9");
      end
      @(negedge clk);
      load = 1'b0;
      de = 1'b0;
      repeat (4) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data = {3'b010, new_c};
      @(negedge clk);
      cmd_valid = 1'b0;
      m_pal[1] = new_c;
      repeat (14) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule